// File: doc/BRIEF.md
# Battery Voltage Window Alarm

This block compares a stream of digitized battery-voltage samples, in millivolts, against a lower and an upper threshold. Software sets the thresholds, the timing and the comparator enables through four byte-wide registers. A comparison runs only on an update event. The update mode picks where that event comes from: nowhere, an external reference qualifier pulse, a prescaled and divided version of a 1024 Hz tick, or every clock cycle.

A comparator flags a violation only when the voltage stays outside its threshold across consecutive update events that together span the programmed hold time. That violation then becomes a status bit. The first update event that sees the voltage back inside clears the bit. The alarm output is the OR of the two status bits, so both its rising edge and its falling edge mean something to the system.

The sample input is a valid/ready stream that never applies back-pressure. `smp_ready` is always high, and every cycle with `smp_valid` high replaces the held sample.

Top module: `batt_window_alarm`

## Requirements
- R1: After reset, the registers read as follows: address 0 (thresholds) = 0x00, address 1 (control 1) = 0x00, address 2 (control 2) = 0xC0 with both comparators disabled, and address 3 (update control) = 0x00 (mode never). `alarm` is 0.
- R2: Each threshold is decoded from a coarse step C, a fine step F and an extension bit E, with k = 4*C + F:
  - E = 0 gives 2800 + 25k mV.
  - E = 1 and C <= 2 gives 2500 + 25k mV.
  - E = 1 and C >= 3 gives 4400 + 25(k-12) mV.
- R3: Field positions and compare rules:
  - Address 0: bits 7:4 hold the upper C and bits 3:0 hold the lower C.
  - Address 2: bit 7 is the upper disable, bit 6 is the lower disable, bits 5:4 hold the upper F, bit 3 is the upper E, bits 2:1 hold the lower F, and bit 0 is the lower E.
  - "Below" means the sample is strictly less than the lower threshold. "Above" means the sample is strictly greater than the upper threshold.
- R4: Hold time. Address 1 bits 6:4 hold a code h. A status bit sets on an update event only when the voltage was already in violation at the previous update event, and at least 2^h pulses of `tick_1k` have arrived since the first update event of that violation.
- R5: The first update event that finds the voltage inside the threshold clears that status bit on the same clock edge.
- R6: Address 1 bit 7 is the master enable. When the master enable is 0, or when a comparator's disable bit is 1, that comparator's status bit and hold state are cleared on the next edge.
- R7: Address 3 bits 7:6 select the update mode:
  - 00: no update events.
  - 01: an update event on each `ref_qual` cycle.
  - 10: an update event every (D+1)*2^(P+2) pulses of `tick_1k`, where P is bits 5:3 and D is bits 2:0.
  - 11: an update event every cycle.
- R8: Address 1 reads status "above" in bit 1 and status "below" in bit 0. Writes to those bits are ignored. `alarm` is high while either status bit is set.
- R9: A write to address 1 or address 3 restarts the update divider and both hold counters. A violation in progress must then build up its hold time again from the start.
- R10: `smp_ready` is always 1 and a sample is captured on every cycle with `smp_valid`. No update event occurs before the first sample is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1k | input | 1 | One-cycle pulse at 1024 Hz |
| ref_qual | input | 1 | Update qualifier used in mode 01 |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready, always 1 |
| smp_mv | input | SAMPLE_W | Battery voltage in mV |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| alarm | output | 1 | High while either status bit is set |

## Verification
The thresholds are driven through all three decode bands. At each band edge the sample is placed exactly on the threshold and one millivolt outside it. This separates the band offsets from each other and strict compares from inclusive ones. Hold tests count `tick_1k` pulses right up to the one that should set the status bit, and a restart in the middle of a violation shows that the hold count starts again. The update modes are told apart by how many ticks, or how many qualifier pulses, it takes for a violation to appear.

// File: rtl/bva_pkg.sv
package bva_pkg;
  localparam int MV_W = 13;

  typedef enum logic [1:0] {
    UPD_NEVER  = 2'b00,
    UPD_REFQ   = 2'b01,
    UPD_PWM    = 2'b10,
    UPD_ALWAYS = 2'b11
  } upd_mode_e;

  localparam logic [1:0] A_THR  = 2'd0;
  localparam logic [1:0] A_CTL1 = 2'd1;
  localparam logic [1:0] A_CTL2 = 2'd2;
  localparam logic [1:0] A_RATE = 2'd3;

  typedef struct packed {
    logic [3:0] coarse;
    logic [1:0] fine;
    logic       ext;
  } thr_code_t;

  // coarse/fine code to millivolts, three bands
  function automatic logic [MV_W-1:0] thr_to_mv(thr_code_t c);
    int unsigned k;
    int unsigned mv;
    k = 4 * int'(c.coarse) + int'(c.fine);
    if (!c.ext)             mv = 2800 + 25 * k;
    else if (c.coarse <= 2) mv = 2500 + 25 * k;
    else                    mv = 4400 + 25 * (k - 12);
    return MV_W'(mv);
  endfunction
endpackage

// File: rtl/bva_regs.sv
module bva_regs
  import bva_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic [1:0] status,
  output thr_code_t  code_lo,
  output thr_code_t  code_hi,
  output logic [1:0] cmp_dis,
  output logic       master_en,
  output logic [2:0] hold_sel,
  output upd_mode_e  mode,
  output logic [2:0] pre_sel,
  output logic [2:0] div_sel,
  output logic       restart
);
  logic [7:0] r_thr;
  logic [3:0] r_c1;
  logic [7:0] r_c2;
  logic [7:0] r_rate;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_thr  <= 8'h00;
      r_c1   <= 4'h0;
      r_c2   <= 8'hC0;
      r_rate <= 8'h00;
    end else if (wr_en) begin
      case (wr_addr)
        A_THR:   r_thr  <= wr_data;
        A_CTL1:  r_c1   <= wr_data[7:4];
        A_CTL2:  r_c2   <= wr_data;
        default: r_rate <= wr_data;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      A_THR:   rd_data = r_thr;
      A_CTL1:  rd_data = {r_c1, 2'b00, status};
      A_CTL2:  rd_data = r_c2;
      default: rd_data = r_rate;
    endcase
  end

  assign code_lo   = '{coarse: r_thr[3:0], fine: r_c2[2:1], ext: r_c2[0]};
  assign code_hi   = '{coarse: r_thr[7:4], fine: r_c2[5:4], ext: r_c2[3]};
  assign cmp_dis   = {r_c2[7], r_c2[6]};
  assign master_en = r_c1[3];
  assign hold_sel  = r_c1[2:0];
  assign mode      = upd_mode_e'(r_rate[7:6]);
  assign pre_sel   = r_rate[5:3];
  assign div_sel   = r_rate[2:0];
  assign restart   = wr_en && (wr_addr == A_CTL1 || wr_addr == A_RATE);

  AST_CTL2_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == A_CTL2) |=> $stable(r_c2)); // R6
endmodule

// File: rtl/bva_rate.sv
module bva_rate
  import bva_pkg::*;
#(
  parameter int MAX_SCALER = 9,
  parameter int DIV_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1k,
  input  logic             ref_qual,
  input  upd_mode_e        mode,
  input  logic [2:0]       pre_sel,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             restart,
  output logic             eval
);
  localparam int PRE_W = MAX_SCALER;

  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [PRE_W-1:0] pre_lim;
  logic             pre_wrap;
  logic             pwm_tick;

  assign pre_lim  = PRE_W'((1 << (int'(pre_sel) + 2)) - 1);
  assign pre_wrap = tick_1k && (pre_cnt == pre_lim);
  assign pwm_tick = (mode == UPD_PWM) && !restart && pre_wrap && (div_cnt == div_sel);

  always_ff @(posedge clk) begin
    if (!rst_n || restart || mode != UPD_PWM) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (tick_1k) begin
      if (pre_wrap) begin
        pre_cnt <= '0;
        div_cnt <= (div_cnt == div_sel) ? '0 : div_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (mode)
      UPD_NEVER:  eval = 1'b0;
      UPD_REFQ:   eval = ref_qual;
      UPD_PWM:    eval = pwm_tick;
      default:    eval = 1'b1;
    endcase
  end

  AST_PWM_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_tick |=> (pre_cnt == '0 && div_cnt == '0)); // R7
endmodule

// File: rtl/bva_window.sv
module bva_window #(
  parameter int HOLD_SEL_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  eval,
  input  logic                  tick,
  input  logic                  restart,
  input  logic                  viol,
  input  logic [HOLD_SEL_W-1:0] hold_sel,
  output logic                  status
);
  localparam int CNT_W = (1 << HOLD_SEL_W);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] target;
  logic             in_viol;

  assign target = CNT_W'(1) << hold_sel;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt     <= '0;
      in_viol <= 1'b0;
      status  <= 1'b0;
    end else if (restart) begin
      cnt     <= '0;
      in_viol <= 1'b0;
    end else begin
      if (tick && in_viol && cnt != '1) cnt <= cnt + 1'b1;
      if (eval) begin
        if (viol) begin
          in_viol <= 1'b1;
          if (in_viol && cnt >= target) status <= 1'b1;
        end else begin
          in_viol <= 1'b0;
          cnt     <= '0;
          status  <= 1'b0;
        end
      end
    end
  end

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !status); // R6
  AST_RISE_NEEDS_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status) |-> $past(eval && viol && in_viol)); // R4
  AST_FALL_ON_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status) |-> $past(!en || (eval && !viol))); // R5
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && en) |=> (cnt == '0 && !in_viol)); // R9
endmodule

// File: rtl/batt_window_alarm.sv
module batt_window_alarm
  import bva_pkg::*;
#(
  parameter int SAMPLE_W   = 13,
  parameter int MAX_SCALER = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_1k,
  input  logic                ref_qual,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_mv,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [7:0]          wr_data,
  input  logic [1:0]          rd_addr,
  output logic [7:0]          rd_data,
  output logic                alarm
);
  localparam int NCMP = 2;

  thr_code_t     code_lo, code_hi;
  logic [1:0]    cmp_dis;
  logic          master_en;
  logic [2:0]    hold_sel;
  upd_mode_e     mode;
  logic [2:0]    pre_sel, div_sel;
  logic          restart;
  logic          eval_raw, eval_g;
  logic [NCMP-1:0] status, viol, cmp_en;
  logic [SAMPLE_W-1:0] smp_q;
  logic          have_smp;

  assign smp_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_q    <= '0;
      have_smp <= 1'b0;
    end else if (smp_valid) begin
      smp_q    <= smp_mv;
      have_smp <= 1'b1;
    end
  end

  bva_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .status(status),
    .code_lo(code_lo), .code_hi(code_hi), .cmp_dis(cmp_dis), .master_en(master_en),
    .hold_sel(hold_sel), .mode(mode), .pre_sel(pre_sel), .div_sel(div_sel),
    .restart(restart)
  );

  bva_rate #(.MAX_SCALER(MAX_SCALER), .DIV_W(3)) u_rate (
    .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k), .ref_qual(ref_qual), .mode(mode),
    .pre_sel(pre_sel), .div_sel(div_sel), .restart(restart), .eval(eval_raw)
  );

  assign eval_g = eval_raw && have_smp;

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    logic [MV_W-1:0] thr_mv;
    if (g == 0) begin : g_lo
      assign thr_mv = thr_to_mv(code_lo);
      assign viol[g] = smp_q < SAMPLE_W'(thr_mv);
    end else begin : g_hi
      assign thr_mv = thr_to_mv(code_hi);
      assign viol[g] = smp_q > SAMPLE_W'(thr_mv);
    end
    assign cmp_en[g] = master_en && !cmp_dis[g];

    bva_window #(.HOLD_SEL_W(3)) u_win (
      .clk(clk), .rst_n(rst_n), .en(cmp_en[g]), .eval(eval_g), .tick(tick_1k),
      .restart(restart), .viol(viol[g]), .hold_sel(hold_sel), .status(status[g])
    );
  end

  assign alarm = |status;

  AST_WAIT_FIRST_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !have_smp |-> status == '0); // R10
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready); // R10
endmodule

// File: tb/batt_window_alarm_test.sv
module batt_window_alarm_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, tick_1k = 0, ref_qual = 0, smp_valid = 0;
  logic smp_ready, alarm;
  logic [12:0] smp_mv = '0;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  batt_window_alarm uut (
    .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k), .ref_qual(ref_qual),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_mv(smp_mv),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .alarm(alarm)
  );

  function automatic int exp_mv(int c, int f, int e);
    int k = 4 * c + f;
    if (e == 0) return 2800 + 25 * k;
    if (c <= 2) return 2500 + 25 * k;
    return 4400 + 25 * (k - 12);
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic clocks(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reg_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic reg_rd(logic [1:0] a, output int v);
    rd_addr = a; #1; v = int'(rd_data);
  endtask

  task automatic put_sample(int mv);
    @(negedge clk); smp_valid = 1; smp_mv = 13'(mv);
    @(negedge clk); smp_valid = 0;
  endtask

  task automatic tick();
    @(negedge clk); tick_1k = 1;
    @(negedge clk); tick_1k = 0;
  endtask

  task automatic settle();
    clocks(2); tick(); clocks(2); tick(); clocks(2);
  endtask

  task automatic status_is(string req, int exp);
    int v;
    reg_rd(2'd1, v);
    check(req, v & 3, exp);
    check(req, int'(alarm), exp != 0 ? 1 : 0);
  endtask

  task automatic t_reset();
    int v;
    reg_rd(2'd0, v); check("R1 thr", v, 8'h00);
    reg_rd(2'd1, v); check("R1 ctl1", v, 8'h00);
    reg_rd(2'd2, v); check("R1 ctl2", v, 8'hC0);
    reg_rd(2'd3, v); check("R1 rate", v, 8'h00);
    check("R1 alarm", int'(alarm), 0);
  endtask

  // lower: C=4 F=2 E=0 (3250); upper: C=15 F=3 E=1 (5675)
  task automatic t_no_sample();
    reg_wr(2'd0, 8'hF4);
    reg_wr(2'd2, 8'b0011_1100);
    reg_wr(2'd3, 8'hC0);
    reg_wr(2'd1, 8'h80);
    settle();
    status_is("R10 no sample yet", 0);
    check("R10 ready", int'(smp_ready), 1);
  endtask

  task automatic t_bands();
    check("R2 model", exp_mv(4, 2, 0), 3250);
    put_sample(3250); settle(); status_is("R3 equal lower", 0);
    put_sample(3249); settle(); status_is("R3 below lower R8", 1);
    put_sample(3300); clocks(1); status_is("R5 clear on first eval", 0);
    put_sample(5675); settle(); status_is("R3 equal upper", 0);
    put_sample(5676); settle(); status_is("R2 high ext top R8", 2);
    put_sample(3300); settle();
    // lower C=2 F=1 E=1 -> 2725 ; upper C=3 F=0 E=1 -> 4400
    reg_wr(2'd0, 8'h32);
    reg_wr(2'd2, 8'b0000_1011);
    put_sample(exp_mv(2, 1, 1) - 1); settle(); status_is("R2 low ext band", 1);
    put_sample(exp_mv(2, 1, 1)); settle(); status_is("R2 low ext edge", 0);
    put_sample(exp_mv(3, 0, 1) + 1); settle(); status_is("R2 high ext band", 2);
    put_sample(exp_mv(3, 0, 1)); settle(); status_is("R2 high ext edge", 0);
    // upper C=15 F=3 E=0 -> 4375
    reg_wr(2'd0, 8'hF2);
    reg_wr(2'd2, 8'b0011_0011);
    put_sample(4376); settle(); status_is("R2 basic band top", 2);
    put_sample(3300); settle();
    reg_wr(2'd0, 8'hF4);
    reg_wr(2'd2, 8'b0011_1100);
  endtask

  task automatic t_hold();
    reg_wr(2'd1, 8'hA0);           // h=2 -> 4 ticks
    put_sample(3000); clocks(1);
    for (int i = 0; i < 3; i++) tick();
    tick(); status_is("R4 before hold done", 0);
    clocks(1); status_is("R4 hold met", 1);
    put_sample(3300); clocks(1); status_is("R5 clears", 0);
  endtask

  task automatic t_restart();
    put_sample(3000); clocks(1);
    for (int i = 0; i < 3; i++) tick();
    reg_wr(2'd3, 8'hC0);
    clocks(1);
    for (int i = 0; i < 3; i++) tick();
    clocks(1); status_is("R9 hold restarted", 0);
    tick(); clocks(1); status_is("R9 hold after restart", 1);
  endtask

  task automatic t_disable();
    int v;
    reg_wr(2'd2, 8'b0111_1100);
    clocks(1); status_is("R6 lower disabled", 0);
    reg_wr(2'd2, 8'b0011_1100);
    reg_wr(2'd1, 8'h80);
    settle(); status_is("R6 re-enabled", 1);
    reg_wr(2'd1, 8'h00);
    clocks(1); status_is("R6 master off", 0);
    reg_wr(2'd1, 8'h83);
    put_sample(3300); settle();
    reg_rd(2'd1, v); check("R8 status bits read-only", v, 8'h80);
  endtask

  task automatic t_modes();
    reg_wr(2'd3, 8'h00);
    put_sample(3000);
    for (int i = 0; i < 4; i++) tick();
    clocks(2); status_is("R7 mode never", 0);
    reg_wr(2'd3, 8'h40);
    for (int i = 0; i < 3; i++) tick();
    status_is("R7 ref mode no qual", 0);
    @(negedge clk); ref_qual = 1; @(negedge clk); ref_qual = 0;
    tick();
    @(negedge clk); ref_qual = 1; @(negedge clk); ref_qual = 0;
    status_is("R7 ref mode qual", 1);
    reg_wr(2'd3, 8'hC0);
    put_sample(3300); clocks(1); status_is("R5 clear before pwm", 0);
    put_sample(3000);
    reg_wr(2'd3, 8'h81);           // P=0 D=1: every 8 ticks
    for (int i = 0; i < 8; i++) tick();
    status_is("R7 pwm first event", 0);
    for (int i = 0; i < 7; i++) tick();
    status_is("R7 pwm before second", 0);
    tick(); status_is("R7 pwm second event", 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clocks(3);
    rst_n = 1;
    clocks(1);
    t_reset();
    t_no_sample();
    t_bands();
    t_hold();
    t_restart();
    t_disable();
    t_modes();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule